// File: doc/BRIEF.md
# BCD Timekeeper With Serial Access

This block keeps time of day and a calendar in eight byte-wide registers holding BCD values. They are hundredths, seconds, minutes, hours, day of week, date, month and year. A tick input, divided by a small prescaler, advances the hundredths. Carries ripple from the hundredths up through the year. Month lengths and leap years decide when the date wraps, and the hours run in either a 24-hour or a 12-hour format with a PM flag.

All access is one bit at a time. An external unlock matcher presents a 6-bit bit index, where index = register * 8 + bit. It walks from register 0 bit 0 up to register 7 bit 7. A window-start pulse copies all eight registers into a 64-bit read image, so a carry cannot tear a value that is being read out. Written bits are staged and land in a register only when that byte's bit 7 arrives. The day register also holds two control bits: one stops the clock, and the other tells the matcher whether to ignore its external reset pin.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset, the registers read hundredths 00, seconds 00, minutes 00, hours 00 (24-hour), day 0x31 (clock stopped, reset-ignore set, day 1), date 01, month 01 and year 00.
- R2: Bit index i = 8*r + b selects bit b of register r. Register 0 holds hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month and 7 year.
- R3: rdBit shows the image captured on the last winStart cycle. Advances that happen afterwards do not change it until the next winStart.
- R4: A write to bit index i with i mod 8 < 7 only stages that bit. Writing bit 7 commits the whole byte to register i/8 in the same clock edge.
- R5: Bits with no function always read 0 and are discarded on write. The kept-bit masks per register 0..7 are FF, 7F, 7F, BF, 37, 3F, 1F, FF.
- R6: Day bit 5 = 1 stops timekeeping. With day bit 5 = 0, every PRESCALE-th tick pulse advances the hundredths by one.
- R7: In 24-hour mode (hours bit 7 = 0), 23:59:59.99 rolls to 00:00:00.00. The date advances, and the day of week steps 1..7 and wraps from 7 to 1.
- R8: In 12-hour mode (hours bit 7 = 1, bit 5 = PM, hours 01..12), 11:59:59.99 goes to 12 with PM toggled and 12 goes to 01. The date advances only on the PM-to-AM change.
- R9: The date wraps to 01 after 28 or 29 in February, 30 in April, June, September and November, and 31 otherwise. A year is a leap year when its two-digit value is divisible by 4.
- R10: 31 December of year 99 rolls to 01 January of year 00.
- R11: A commit to register 0 clears the tick prescaler, so the next advance needs a full PRESCALE pulses.
- R12: When a commit and a prescaler expiry fall in the same cycle, the commit is applied and that advance is dropped.
- R13: rstIgnore equals day register bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | One-cycle timebase pulse |
| winStart | input | 1 | Captures the registers into the read image |
| accValid | input | 1 | Bit access strobe |
| accWrite | input | 1 | 1 = write access, 0 = read |
| accIdx | input | 6 | Bit index, 8*register + bit |
| accWrData | input | 1 | Write data bit |
| rdBit | output | 1 | Read image bit at accIdx |
| rstIgnore | output | 1 | Day register bit 4 |

## Verification
Two functions can fall in the same cycle: a byte commit and a prescaler expiry. The bench sets the prescaler one pulse short of expiry. It then raises tickIn in the very cycle that carries bit 7 of a seconds write. After that it reads back the new seconds with unchanged hundredths. Two further pulses must then be needed to move the hundredths, which shows that the prescaler wrapped and the step was dropped.

// File: rtl/tk_pkg.sv
`timescale 1ns/1ps
package tk_pkg;
  localparam int NUM_REGS = 8;
  localparam int REG_W    = 8;
  localparam int IMG_W    = NUM_REGS * REG_W;
  localparam int IDX_W    = $clog2(IMG_W);
  localparam int SEL_W    = $clog2(NUM_REGS);

  typedef struct packed {
    logic             snap;
    logic             adv;
    logic             commit;
    logic [SEL_W-1:0] commitSel;
    logic [REG_W-1:0] commitData;
  } tkStrobe_t;

  function automatic logic [REG_W-1:0] keepMask(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1, 3'd2: return 8'h7F;
      3'd3:       return 8'hBF;
      3'd4:       return 8'h37;
      3'd5:       return 8'h3F;
      3'd6:       return 8'h1F;
      default:    return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/tk_ctrl.sv
`timescale 1ns/1ps
module tk_ctrl import tk_pkg::*; #(
  parameter int PRESCALE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             winStart,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [IDX_W-1:0] accIdx,
  input  logic             accWrData,
  input  logic             oscStop,
  output tkStrobe_t        strb
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic [REG_W-2:0] stageBits;
  logic             isWr, byteEnd, preHit, preClr;

  assign isWr    = accValid && accWrite;
  assign byteEnd = isWr && (accIdx[2:0] == 3'd7);
  assign preHit  = tickIn && !oscStop && (preCnt == PRE_LAST);
  assign preClr  = byteEnd && (accIdx[IDX_W-1:3] == '0);

  always_comb begin
    strb.snap       = winStart;
    strb.commit     = byteEnd;
    strb.commitSel  = accIdx[IDX_W-1:3];
    strb.commitData = {accWrData, stageBits};
    strb.adv        = preHit && !byteEnd;
  end

  for (genvar g = 0; g < REG_W - 1; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      stageBits[g] <= 1'b0;
      else if (isWr && (accIdx[2:0] == 3'(g)))        stageBits[g] <= accWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  preCnt <= '0;
    else if (preClr)            preCnt <= '0;
    else if (tickIn && !oscStop) preCnt <= preHit ? '0 : preCnt + 1'b1;
  end

  // R11
  prescaler_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.commitSel == '0) |=> (preCnt == '0));

  // R6
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oscStop && !(strb.commit && strb.commitSel == '0)) |=> $stable(preCnt));
endmodule

// File: rtl/tk_datapath.sv
`timescale 1ns/1ps
module tk_datapath import tk_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  tkStrobe_t        strb,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdBit,
  output logic             oscStop,
  output logic             rstIgnore
);
  logic [REG_W-1:0] timeReg [NUM_REGS];
  logic [REG_W-1:0] nextReg [NUM_REGS];
  logic [IMG_W-1:0] image;
  logic cHund, cSec, cMin, cHour, cDate, cMon;
  logic [4:0] hr12;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  function automatic logic [7:0] monthEnd(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'h2 || yr[3:0] == 4'h6)
                 : (yr[3:0] == 4'h0 || yr[3:0] == 4'h4 || yr[3:0] == 4'h8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] resetVal(input int r);
    case (r)
      4, 5, 6: return (r == 4) ? 8'h31 : 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  assign oscStop   = timeReg[4][5];
  assign rstIgnore = timeReg[4][4];
  assign rdBit     = image[rdIdx];
  assign hr12      = timeReg[3][4:0];

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) nextReg[r] = timeReg[r];
    cHund = timeReg[0] == 8'h99;
    cSec  = cHund && timeReg[1] == 8'h59;
    cMin  = cSec  && timeReg[2] == 8'h59;
    cHour = 1'b0;
    cDate = 1'b0;
    cMon  = 1'b0;
    if (strb.commit) begin
      nextReg[strb.commitSel] = strb.commitData & keepMask(strb.commitSel);
    end else if (strb.adv) begin
      nextReg[0] = cHund ? 8'h00 : bcdInc(timeReg[0]);
      if (cHund) nextReg[1] = (timeReg[1] == 8'h59) ? 8'h00 : bcdInc(timeReg[1]);
      if (cSec)  nextReg[2] = (timeReg[2] == 8'h59) ? 8'h00 : bcdInc(timeReg[2]);
      if (cMin) begin
        if (timeReg[3][7]) begin
          if (hr12 == 5'h12)
            nextReg[3] = {timeReg[3][7], 1'b0, timeReg[3][5], 5'h01};
          else if (hr12 == 5'h11) begin
            nextReg[3] = {timeReg[3][7], 1'b0, ~timeReg[3][5], 5'h12};
            cHour      = timeReg[3][5];
          end else
            nextReg[3] = {timeReg[3][7], 1'b0, timeReg[3][5], bcdInc({3'b0, hr12})[4:0]};
        end else begin
          cHour      = timeReg[3] == 8'h23;
          nextReg[3] = cHour ? 8'h00 : bcdInc(timeReg[3]);
        end
      end
      if (cHour) begin
        nextReg[4] = {timeReg[4][7:3], (timeReg[4][2:0] == 3'd7) ? 3'd1 : timeReg[4][2:0] + 3'd1};
        cDate      = timeReg[5] == monthEnd(timeReg[6], timeReg[7]);
        nextReg[5] = cDate ? 8'h01 : bcdInc(timeReg[5]);
      end
      if (cDate) begin
        cMon       = timeReg[6] == 8'h12;
        nextReg[6] = cMon ? 8'h01 : bcdInc(timeReg[6]);
      end
      if (cMon) nextReg[7] = (timeReg[7] == 8'h99) ? 8'h00 : bcdInc(timeReg[7]);
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        timeReg[r]               <= resetVal(r);
        image[r*REG_W +: REG_W]  <= resetVal(r);
      end else begin
        timeReg[r] <= nextReg[r];
        if (strb.snap) image[r*REG_W +: REG_W] <= timeReg[r];
      end
    end
  end

  // R5
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeReg[1][7] == 1'b0) && (timeReg[2][7] == 1'b0) && (timeReg[3][6] == 1'b0) &&
    (timeReg[4][7:6] == 2'b00) && (timeReg[4][3] == 1'b0) && (timeReg[5][7:6] == 2'b00) &&
    (timeReg[6][7:5] == 3'b000));

  // R12
  commit_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.commitSel != '0) |=> $stable(timeReg[0]));

  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oscStop && !strb.commit) |=> $stable(timeReg[0]));

  // R7
  adv_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.adv |=> !$stable(timeReg[0]));
endmodule

// File: rtl/bcd_timekeeper.sv
`timescale 1ns/1ps
module bcd_timekeeper import tk_pkg::*; #(
  parameter int PRESCALE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             winStart,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [5:0]       accIdx,
  input  logic             accWrData,
  output logic             rdBit,
  output logic             rstIgnore
);
  tkStrobe_t strb;
  logic      oscStop;

  tk_ctrl #(.PRESCALE(PRESCALE)) uCtrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .winStart(winStart),
    .accValid(accValid), .accWrite(accWrite), .accIdx(accIdx),
    .accWrData(accWrData), .oscStop(oscStop), .strb(strb)
  );

  tk_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rdIdx(accIdx),
    .rdBit(rdBit), .oscStop(oscStop), .rstIgnore(rstIgnore)
  );
endmodule

// File: tb/bcd_timekeeper_test.sv
`timescale 1ns/1ps
module bcd_timekeeper_test;
  logic clk = 1'b0, rstN = 1'b0, tickIn = 1'b0, winStart = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0, accWrData = 1'b0;
  logic [5:0] accIdx = '0;
  logic rdBit, rstIgnore;
  int testCnt = 0, failCnt = 0;

  always #2.5 clk = ~clk;

  bcd_timekeeper #(.PRESCALE(2)) uut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .winStart(winStart),
    .accValid(accValid), .accWrite(accWrite), .accIdx(accIdx),
    .accWrData(accWrData), .rdBit(rdBit), .rstIgnore(rstIgnore)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeBit(input int idx, input logic d, input logic tk);
    @(negedge clk);
    accValid = 1'b1; accWrite = 1'b1; accIdx = 6'(idx); accWrData = d; tickIn = tk;
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; tickIn = 1'b0;
  endtask

  task automatic writeImage(input logic [63:0] img);
    for (int i = 0; i < 64; i++) writeBit(i, img[i], 1'b0);
    idle();
  endtask

  task automatic writeByte(input int r, input logic [7:0] v, input logic tickLast);
    for (int b = 0; b < 8; b++) writeBit(r*8 + b, v[b], (b == 7) ? tickLast : 1'b0);
    idle();
  endtask

  task automatic readImage(input bit doSnap, output logic [63:0] img);
    if (doSnap) begin
      @(negedge clk); winStart = 1'b1;
      @(negedge clk); winStart = 1'b0;
    end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      accValid = 1'b1; accWrite = 1'b0; accIdx = 6'(i);
      #1 img[i] = rdBit;
    end
    idle();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
    end
  endtask

  task automatic rollCheck(input logic [63:0] start, input logic [63:0] exp, input string req);
    logic [63:0] got;
    writeImage(start);
    ticks(2);
    readImage(1'b1, got);
    chk(got == exp, req, got, exp);
  endtask

  task automatic testReset();
    logic [63:0] got;
    readImage(1'b1, got);
    chk(got == 64'h00010131_00000000, "R1 reset image", got, 64'h00010131_00000000);
    chk(rstIgnore == 1'b1, "R13 reset rstIgnore", 64'(rstIgnore), 64'h1);
    ticks(4);
    readImage(1'b1, got);
    chk(got == 64'h00010131_00000000, "R6 stopped clock holds", got, 64'h00010131_00000000);
  endtask

  task automatic testOrder();
    logic [63:0] got;
    writeImage(64'h45081723_13563412);
    readImage(1'b1, got);
    chk(got == 64'h45081723_13563412, "R2 byte and bit order", got, 64'h45081723_13563412);
    chk(rstIgnore == 1'b0, "R13 rstIgnore cleared", 64'(rstIgnore), 64'h0);
  endtask

  task automatic testMask();
    logic [63:0] got;
    writeImage('1);
    readImage(1'b1, got);
    chk(got == 64'hFF1F3F37_BF7F7FFF, "R5 unused bits read 0", got, 64'hFF1F3F37_BF7F7FFF);
  endtask

  task automatic testStaging();
    logic [63:0] got;
    writeImage(64'h45081723_13563412);
    for (int b = 0; b < 7; b++) writeBit(16 + b, 8'h21 >> b, 1'b0);
    idle();
    readImage(1'b1, got);
    chk(got[23:16] == 8'h56, "R4 staged bits not committed", 64'(got[23:16]), 64'h56);
    writeBit(23, 1'b0, 1'b0);
    idle();
    readImage(1'b1, got);
    chk(got[23:16] == 8'h21, "R4 commit on bit 7", 64'(got[23:16]), 64'h21);
  endtask

  task automatic testSnapshot();
    logic [63:0] got;
    writeImage(64'h21061501_00000000);
    @(negedge clk); winStart = 1'b1;
    @(negedge clk); winStart = 1'b0;
    ticks(2);
    readImage(1'b0, got);
    chk(got[7:0] == 8'h00, "R3 image frozen after snap", 64'(got[7:0]), 64'h00);
    readImage(1'b1, got);
    chk(got[7:0] == 8'h01, "R3 new snap shows advance", 64'(got[7:0]), 64'h01);
  endtask

  task automatic testRollovers();
    rollCheck(64'h21061507_23595999, 64'h21061601_00000000, "R7 24h midnight, day 7 to 1");
    rollCheck(64'h21061003_91595999, 64'h21061003_B2000000, "R8 11 AM to 12 PM");
    rollCheck(64'h21061003_B2595999, 64'h21061003_A1000000, "R8 12 PM to 01 PM");
    rollCheck(64'h21061003_B1595999, 64'h21061104_92000000, "R8 11 PM to 12 AM");
    rollCheck(64'h23022802_23595999, 64'h23030103_00000000, "R9 Feb 28 non-leap");
    rollCheck(64'h24022802_23595999, 64'h24022903_00000000, "R9 Feb 28 leap 24");
    rollCheck(64'h12022802_23595999, 64'h12022903_00000000, "R9 Feb 28 leap 12");
    rollCheck(64'h24022902_23595999, 64'h24030103_00000000, "R9 Feb 29 to Mar 01");
    rollCheck(64'h24043002_23595999, 64'h24050103_00000000, "R9 Apr 30 to May 01");
    rollCheck(64'h99123107_23595999, 64'h00010101_00000000, "R10 year 99 to 00");
  endtask

  task automatic testPrescaleClear();
    logic [63:0] got;
    writeImage(64'h21061501_00000000);
    ticks(1);
    writeByte(0, 8'h50, 1'b0);
    ticks(1);
    readImage(1'b1, got);
    chk(got[7:0] == 8'h50, "R11 no step after clear", 64'(got[7:0]), 64'h50);
    ticks(1);
    readImage(1'b1, got);
    chk(got[7:0] == 8'h51, "R11 step after full count", 64'(got[7:0]), 64'h51);
  endtask

  task automatic testCollision();
    logic [63:0] got;
    writeImage(64'h21061501_00000040);
    ticks(1);
    writeByte(1, 8'h33, 1'b1);
    readImage(1'b1, got);
    chk(got[15:0] == 16'h3340, "R12 commit wins over step", 64'(got[15:0]), 64'h3340);
    ticks(1);
    readImage(1'b1, got);
    chk(got[7:0] == 8'h40, "R12 prescaler wrapped", 64'(got[7:0]), 64'h40);
    ticks(1);
    readImage(1'b1, got);
    chk(got[7:0] == 8'h41, "R12 next step", 64'(got[7:0]), 64'h41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOrder();
    testMask();
    testStaging();
    testSnapshot();
    testRollovers();
    testPrescaleClear();
    testCollision();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #500000;
    testCnt++;
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule